// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between the execute stage of a 32-bit integer datapath and a word-organised data memory. For each access it forms the effective byte address from a base register and a signed 16-bit byte displacement. It drops the two low address bits to give the memory word address. It also decides which byte lanes of the memory word take part in the access.

For a store, the unit drives per-lane write enables and places the store data on the lanes that the enables select. For a load, it records the lane position, size and signedness of the request. One cycle later it takes the word returned by memory, picks out the addressed byte or halfword and widens it to a full 32-bit result. Byte order is big-endian: byte offset 0 of a word is its most significant byte. A halfword or word access at an address that is not a multiple of its size raises a misalign flag, and no memory operation is issued for it.

Top module: `be_lane_lsu`

## Requirements
- R1: `mem_addr_o` equals bits 31:2 of the effective address `base_i + sign_extend(offset_i)`, computed in 32-bit wrap-around arithmetic, whenever a strobe is present.
- R2: With `size_i` encoded 0 = byte, 1 = halfword, 2 or 3 = word, `misalign_o` is 1 during a strobe exactly when the access is a halfword with effective address bit 0 set, or a word with effective address bits 1:0 not both zero. A byte access is never misaligned.
- R3: While `misalign_o` is 1, `mem_be_o` is 0, `mem_we_o` and `mem_re_o` are 0, and `load_valid_o` stays 0 in the following cycle.
- R4: An aligned byte store at byte offset k (effective address bits 1:0) sets only `mem_be_o` bit 3-k, where bit i enables data bits 8i+7:8i. It drives the low byte of `wdata_i` onto all four lanes of `mem_wdata_o`.
- R5: An aligned halfword store sets `mem_be_o` to 4'b1100 at offset 0 and to 4'b0011 at offset 2. It drives the low halfword of `wdata_i` onto both halves of `mem_wdata_o`.
- R6: An aligned word store sets `mem_be_o` to 4'b1111 and `mem_wdata_o` to `wdata_i`. `mem_we_o` is 1 for every aligned store.
- R7: An aligned load raises `mem_re_o` in the same cycle. `load_valid_o` is 1 in exactly the next cycle, and `load_data_o` is then formed from `mem_rdata_i` of that cycle. At all other times `load_valid_o` and `load_data_o` are 0.
- R8: A byte load at offset k takes bits 31-8k down to 24-8k of the memory word. A halfword load takes bits 31:16 at offset 0 and bits 15:0 at offset 2.
- R9: With `unsigned_i` = 0, a byte or halfword load copies the sign bit of the selected data into all upper bits of `load_data_o`.
- R10: With `unsigned_i` = 1, a byte or halfword load fills the upper bits of `load_data_o` with zeros.
- R11: A word load returns the whole memory word, whatever the value of `unsigned_i`.
- R12: With neither strobe set, `mem_be_o`, `mem_we_o`, `mem_re_o` and `misalign_o` are all 0.
- R13: If `load_i` and `store_i` are both set, the access is a store: `mem_re_o` is 0 and no load result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte displacement |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| unsigned_i | input | 1 | Zero-extend sub-word loads when 1 |
| wdata_i | input | 32 | Store data, right-aligned |
| load_i | input | 1 | Load strobe |
| store_i | input | 1 | Store strobe |
| mem_addr_o | output | 30 | Memory word address |
| mem_be_o | output | 4 | Byte-lane write enables, bit i for bits 8i+7:8i |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_we_o | output | 1 | Memory write request |
| mem_re_o | output | 1 | Memory read request |
| misalign_o | output | 1 | Misaligned access flag |
| mem_rdata_i | input | 32 | Memory read word, one cycle after `mem_re_o` |
| load_data_o | output | 32 | Extended load result |
| load_valid_o | output | 1 | Load result valid |

## Verification
The bench aims at the lane mapping at each of the four byte offsets and both halfword offsets. A little-endian mapping would enable the mirrored lane and return the wrong byte. Sub-word loads use data with the top bit both set and clear, so a swapped or missing sign extension shows up as wrong upper bits. Halfword and word accesses are driven at every low-address pattern, negative displacements are included, and a design that checks the wrong address bits or still enables lanes on a misaligned access is caught by the enable, request and valid checks. Idle cycles and cycles with both strobes set check that nothing is issued by mistake and that the store wins.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3   // treated as word
  } acc_size_e;
endpackage

// File: rtl/be_lsu_agen.sv
module be_lsu_agen #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [1:0]        size_i,
  input  logic              active_i,
  output logic [DATA_W-1:0] ea_o,
  output logic              misalign_o
);
  import be_lsu_pkg::*;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);

  assign ea_o = base_i + {{(DATA_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = active_i & ea_o[0];
      default: misalign_o = active_i & (|ea_o[LANE_AW-1:0]);
    endcase
  end
endmodule

// File: rtl/be_lsu_stlane.sv
module be_lsu_stlane #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane_off_i,
  input  logic [1:0]                  size_i,
  input  logic                        en_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W/8-1:0]         be_o,
  output logic [DATA_W-1:0]           wdata_o
);
  import be_lsu_pkg::*;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // bit i carries bits 8i+7:8i, which is byte offset LANES-1-i (big-endian)
    localparam int OFS = LANES - 1 - i;
    logic sel;
    always_comb begin
      unique case (acc_size_e'(size_i))
        SZ_BYTE: begin
          sel = (lane_off_i == LANE_AW'(OFS));
          wdata_o[8*i +: 8] = wdata_i[7:0];
        end
        SZ_HALF: begin
          sel = ((lane_off_i >> 1) == LANE_AW'(OFS >> 1));
          wdata_o[8*i +: 8] = wdata_i[8*(i%2) +: 8];
        end
        default: begin
          sel = 1'b1;
          wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
        end
      endcase
    end
    assign be_o[i] = en_i & sel;
  end
endmodule

// File: rtl/be_lsu_ldext.sv
module be_lsu_ldext #(
  parameter int DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [$clog2(DATA_W/8)-1:0] lane_off_i,
  input  logic [1:0]                  size_i,
  input  logic                        unsigned_i,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic [DATA_W-1:0]           data_o,
  output logic                        valid_o
);
  import be_lsu_pkg::*;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);

  logic               valid_q, uns_q;
  logic [LANE_AW-1:0] off_q;
  logic [1:0]         size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      uns_q   <= 1'b0;
      off_q   <= '0;
      size_q  <= '0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        uns_q  <= unsigned_i;
        off_q  <= lane_off_i;
        size_q <= size_i;
      end
    end
  end

  logic [DATA_W-1:0] sh_b, sh_h, ext;
  // inverted offset = LANES-1-offset: shift the addressed unit down to bit 0
  assign sh_b = rdata_i >> {~off_q, 3'b000};
  assign sh_h = rdata_i >> {~off_q[LANE_AW-1:1], 4'b0000};

  always_comb begin
    unique case (acc_size_e'(size_q))
      SZ_BYTE: ext = {{(DATA_W-8){~uns_q & sh_b[7]}}, sh_b[7:0]};
      SZ_HALF: ext = {{(DATA_W-16){~uns_q & sh_h[15]}}, sh_h[15:0]};
      default: ext = rdata_i;
    endcase
  end

  assign data_o  = valid_q ? ext : '0;
  assign valid_o = valid_q;

  assert_sext_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !uns_q && size_q == 2'd0) |-> data_o[DATA_W-1:8] == {(DATA_W-8){data_o[7]}});
  assert_zext_half_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && uns_q && size_q == 2'd1) |-> data_o[DATA_W-1:16] == '0);
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0);
endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int LANES   = DATA_W / 8,
  localparam int LANE_AW = $clog2(LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DATA_W-1:0]         base_i,
  input  logic [OFF_W-1:0]          offset_i,
  input  logic [1:0]                size_i,
  input  logic                      unsigned_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      load_i,
  input  logic                      store_i,
  output logic [DATA_W-LANE_AW-1:0] mem_addr_o,
  output logic [LANES-1:0]          mem_be_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  output logic                      mem_we_o,
  output logic                      mem_re_o,
  output logic                      misalign_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic [DATA_W-1:0]         load_data_o,
  output logic                      load_valid_o
);
  logic [DATA_W-1:0] ea;
  logic active, st_en, ld_en;

  assign active = load_i | store_i;

  be_lsu_agen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_agen (
    .base_i(base_i), .offset_i(offset_i), .size_i(size_i),
    .active_i(active), .ea_o(ea), .misalign_o(misalign_o)
  );

  assign st_en      = store_i & ~misalign_o;
  assign ld_en      = load_i & ~store_i & ~misalign_o;  // store wins
  assign mem_we_o   = st_en;
  assign mem_re_o   = ld_en;
  assign mem_addr_o = ea[DATA_W-1:LANE_AW];

  be_lsu_stlane #(.DATA_W(DATA_W)) u_st (
    .lane_off_i(ea[LANE_AW-1:0]), .size_i(size_i), .en_i(st_en),
    .wdata_i(wdata_i), .be_o(mem_be_o), .wdata_o(mem_wdata_o)
  );

  be_lsu_ldext #(.DATA_W(DATA_W)) u_ld (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(ld_en),
    .lane_off_i(ea[LANE_AW-1:0]), .size_i(size_i), .unsigned_i(unsigned_i),
    .rdata_i(mem_rdata_i), .data_o(load_data_o), .valid_o(load_valid_o)
  );

  assert_misalign_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0 && !mem_we_o && !mem_re_o));
  assert_misalign_noresult_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !load_valid_o);
  assert_byte_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == 2'd0) |-> $countones(mem_be_o) == 1);
  assert_half_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && size_i == 2'd1) |-> $countones(mem_be_o) == 2);
  assert_word_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && size_i[1]) |-> &mem_be_o);
  assert_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> load_valid_o);
  assert_valid_only_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_re_o |=> !load_valid_o);
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i || store_i) |-> (mem_be_o == '0 && !mem_we_o && !mem_re_o && !misalign_o));
  assert_store_wins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && store_i) |-> !mem_re_o);
endmodule

// File: tb/sim_be_lane_lsu.sv
module sim_be_lane_lsu;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] base_i = '0, wdata_i = '0, mem_rdata_i = '0;
  logic [15:0] offset_i = '0;
  logic [1:0]  size_i = '0;
  logic        unsigned_i = 1'b0, load_i = 1'b0, store_i = 1'b0;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, load_data_o;
  logic        mem_we_o, mem_re_o, misalign_o, load_valid_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  be_lane_lsu u0 (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] f_ea(logic [31:0] b, logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction
  function automatic bit f_mis(logic [1:0] sz, logic [31:0] ea);
    if (sz == 2'd0) return 1'b0;
    if (sz == 2'd1) return ea[0];
    return ea[1:0] != 2'b00;
  endfunction
  function automatic logic [3:0] f_be(logic [1:0] sz, logic [1:0] k);
    if (sz == 2'd0) return 4'b1000 >> k;
    if (sz == 2'd1) return k[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction
  function automatic logic [31:0] f_wd(logic [1:0] sz, logic [31:0] d);
    if (sz == 2'd0) return {4{d[7:0]}};
    if (sz == 2'd1) return {2{d[15:0]}};
    return d;
  endfunction
  function automatic logic [31:0] f_ld(logic [1:0] sz, logic [1:0] k, bit u, logic [31:0] m);
    logic [7:0] b; logic [15:0] h;
    if (sz == 2'd0) begin
      b = m[31 - 8*k -: 8];
      return u ? {24'd0, b} : {{24{b[7]}}, b};
    end
    if (sz == 2'd1) begin
      h = k[1] ? m[15:0] : m[31:16];
      return u ? {16'd0, h} : {{16{h[15]}}, h};
    end
    return m;
  endfunction

  task automatic do_store(logic [31:0] b, logic [15:0] o, logic [1:0] sz, logic [31:0] d);
    logic [31:0] ea; bit mis;
    ea = f_ea(b, o); mis = f_mis(sz, ea);
    @(negedge clk_i);
    base_i = b; offset_i = o; size_i = sz; wdata_i = d; store_i = 1'b1; load_i = 1'b0;
    #1;
    check("R1 addr", {2'b0, mem_addr_o}, {2'b0, ea[31:2]});
    check("R2 misalign", {31'd0, misalign_o}, {31'd0, mis});
    check(mis ? "R3 be" : (sz == 0 ? "R4 be" : sz == 1 ? "R5 be" : "R6 be"),
          {28'd0, mem_be_o}, mis ? 32'd0 : {28'd0, f_be(sz, ea[1:0])});
    check("R6 we", {31'd0, mem_we_o}, {31'd0, !mis});
    if (!mis)
      check(sz == 0 ? "R4 wdata" : sz == 1 ? "R5 wdata" : "R6 wdata", mem_wdata_o, f_wd(sz, d));
    @(negedge clk_i);
    store_i = 1'b0;
    #1 check("R3 no load result", {31'd0, load_valid_o}, 32'd0);
  endtask

  task automatic do_load(logic [31:0] b, logic [15:0] o, logic [1:0] sz, bit u, logic [31:0] m);
    logic [31:0] ea; bit mis;
    ea = f_ea(b, o); mis = f_mis(sz, ea);
    @(negedge clk_i);
    base_i = b; offset_i = o; size_i = sz; unsigned_i = u; load_i = 1'b1; store_i = 1'b0;
    #1;
    check("R1 addr", {2'b0, mem_addr_o}, {2'b0, ea[31:2]});
    check("R2 misalign", {31'd0, misalign_o}, {31'd0, mis});
    check("R7 re", {31'd0, mem_re_o}, {31'd0, !mis});
    check("R3 be on load", {28'd0, mem_be_o}, 32'd0);
    @(negedge clk_i);
    load_i = 1'b0; mem_rdata_i = m;
    #1;
    check(mis ? "R3 valid" : "R7 valid", {31'd0, load_valid_o}, {31'd0, !mis});
    check(sz[1] ? "R11 data" : (u ? "R10 data" : "R9 R8 data"), load_data_o,
          mis ? 32'd0 : f_ld(sz, ea[1:0], u, m));
  endtask

  initial begin
    int seed;
    logic [31:0] r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);
    #12;
    check("R7 reset valid", {31'd0, load_valid_o}, 32'd0);
    check("R7 reset data", load_data_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check("R12 idle be", {28'd0, mem_be_o}, 32'd0);
    check("R12 idle req", {29'd0, mem_we_o, mem_re_o, misalign_o}, 32'd0);

    // directed: every byte lane, both halves, R8 lane mapping
    for (int k = 0; k < 4; k++) begin
      do_store(32'h1000, 16'(k), 2'd0, 32'hCAFE_F0A5);
      do_load(32'h1000, 16'(k), 2'd0, 1'b0, 32'h8111_F222);
      do_load(32'h1000, 16'(k), 2'd0, 1'b1, 32'h8111_F222);
      do_load(32'h1000, 16'(k), 2'd1, 1'b0, 32'h8123_7456);
      do_store(32'h1000, 16'(k), 2'd1, 32'h1234_9ABC);
      do_store(32'h1000, 16'(k), 2'd2, 32'hDEAD_BEEF);
      do_load(32'h1000, 16'(k), 2'd3, 1'b1, 32'hF00D_0001);
    end
    // negative displacement and wrap
    do_store(32'h0000_0010, 16'hFFF4, 2'd2, 32'h0BAD_F00D);
    do_load(32'h0000_0002, 16'hFFFC, 2'd1, 1'b1, 32'hFFFF_8000);
    do_load(32'h0000_0001, 16'h8000, 2'd0, 1'b0, 32'h0080_0000);

    // both strobes: store wins (R13)
    @(negedge clk_i);
    base_i = 32'h40; offset_i = 16'd3; size_i = 2'd0; wdata_i = 32'h77;
    load_i = 1'b1; store_i = 1'b1;
    #1;
    check("R13 re", {31'd0, mem_re_o}, 32'd0);
    check("R13 we", {31'd0, mem_we_o}, 32'd1);
    check("R13 be", {28'd0, mem_be_o}, 32'h1);
    @(negedge clk_i);
    load_i = 1'b0; store_i = 1'b0; mem_rdata_i = 32'hFFFF_FFFF;
    #1 check("R13 no result", {31'd0, load_valid_o}, 32'd0);
    check("R12 idle again", {28'd0, mem_be_o}, 32'd0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [31:0] b, d; logic [15:0] o; logic [1:0] sz; bit u;
      b = $urandom; d = $urandom; sz = 2'($urandom);
      o = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16) - 16'd8;
      u = 1'($urandom);
      if ($urandom % 2 == 0) b[1:0] = 2'b00 - o[1:0] + (sz == 2'd0 ? 2'($urandom) : 2'b00);
      if (n % 2 == 0) do_store(b, o, sz, d);
      else            do_load(b, o, sz, u, d);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule